// File: doc/BRIEF.md
# Load-Dependent Heartbeat LED

This block drives one status LED with a double-pulse "heartbeat": two short flashes close together, then a pause. It is clocked by the system clock and advances only on a periodic tick strobe, so the visible rate is set by the tick frequency. A system-load figure, given as an unsigned fixed-point number, sets the speed of the beat. A higher load gives a shorter beat cycle, and the cycle length follows a hyperbolic curve toward a floor of 30 ticks.

A beat counter steps once per tick from zero up to the current period value and then returns to zero. At each return to zero the block samples the load input and starts an iterative restoring divider that computes the next period. The offset of the second flash is a quarter of that period. The divider delivers its result long before the counter can need it, provided ticks are spaced by at least the divider latency.

Top module: `heartbeat_led`

## Requirements
- R1: The counter and the LED change only on a clock edge where `tick_i` is high. On every other edge both hold their values.
- R2: The counter steps by one on each tick while it is below the period. On the tick where it is at or above the period it returns to 0, so one beat lasts period+1 ticks.
- R3: On the wrap tick the period becomes floor(672·2^11 / (5·load + 7·2^11)) + 30, where `load_i` is unsigned with 11 fraction bits. This gives 126 at load 0, 86 at load 1.0 (2048), 51 at load 5.0 (10240), and 34 at the largest code 65535.
- R4: The second-flash offset is floor(period/4) of the newly computed period.
- R5: `led_o` goes high on the edge after a tick that brings the counter to 0 or to the offset.
- R6: `led_o` goes low on the edge after a tick that brings the counter to 7 or to offset+7. If a set condition and a clear condition coincide, the set wins.
- R7: `load_i` is sampled only on the wrap tick. A change during a beat does not alter that beat's length or its flash positions.
- R8: After synchronous active-low reset the counter, period, offset and LED are all 0. The first tick therefore wraps at once and lights the LED.
- R9: A new period and offset take effect within NUM_W+2 = 23 clocks of the wrap. Ticks spaced by at least that many clocks always see the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-clock strobe that advances the beat |
| load_i | input | 16 | Unsigned load, 11 fraction bits |
| led_o | output | 1 | Registered LED drive, high = lit |

## Verification
The bench sweeps the load range in coarse steps, covering the stated curve points and the top code. It keeps a tick-level model of the counter, period and offset and compares the LED after every tick and on every idle clock. Ticks are sent at exactly the minimum spacing. A divider whose result lands one clock late would therefore see the stale period on the tick after a wrap and flash a spurious second wrap. A design that read the load continuously instead of at the wrap would cut short the beat in which the load jumps. An off-by-one in the wrap compare would stretch or shorten every beat. A reset that left the period non-zero would delay the first flash.

// File: rtl/hb_pkg.sv
// Shared types and helpers for the heartbeat LED block.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package hb_pkg;

    // Action the beat counter applies to the LED on a tick.
    typedef enum logic [1:0] {
        LED_HOLD = 2'd0,
        LED_SET  = 2'd1,
        LED_CLR  = 2'd2
    } led_act_e;

    // Minimum clocks between ticks so a freshly divided period is in place.
    function automatic int min_tick_gap(input int num_w);
        return num_w + 2;
    endfunction

endpackage

// File: rtl/hb_divider.sv
// Iterative restoring divider, one quotient bit per clock.
// Computes num_i / den_i. A start pulse loads the operands and NUM_W
// iterations follow. done_o pulses for one cycle with quo_o valid.
// Assumes: den_i is non-zero and start_i is not raised while busy_o is high.
module hb_divider #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 19,
    parameter int OUT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [OUT_W-1:0] quo_o
);
    localparam int IT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] den_q;
    logic [IT_W-1:0]  iter_q;
    logic             done_q;

    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   diff;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        rem_sh = {rem_q, quo_q[NUM_W-1]};
        diff   = rem_sh - {1'b0, den_q};
        fits   = ~diff[DEN_W];
    end

    // Operand load, per-bit iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            iter_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                quo_q  <= num_i;
                den_q  <= den_i;
                iter_q <= IT_W'(NUM_W);
            end else if (iter_q != '0) begin
                iter_q <= iter_q - IT_W'(1);
                rem_q  <= fits ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                quo_q  <= {quo_q[NUM_W-2:0], fits};
                if (iter_q == IT_W'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = (iter_q != '0) | done_q;
    assign done_o = done_q;
    assign quo_o  = quo_q[OUT_W-1:0];

endmodule

// File: rtl/hb_period_calc.sv
// Beat period engine. On a wrap pulse it samples the load, forms the
// denominator DEN_K*load + DEN_C*2^FRAC_W and divides the scaled constant
// SCALE*2^FRAC_W by it. When the quotient arrives it registers
// period = quotient + BASE and offset = period / 4.
// Assumes: wrap_i is never raised while busy_o is high.
module hb_period_calc #(
    parameter int LOAD_W = 16,
    parameter int FRAC_W = 11,
    parameter int SCALE  = 672,
    parameter int DEN_K  = 5,
    parameter int DEN_C  = 7,
    parameter int BASE   = 30,
    parameter int NUM_W  = 21,
    parameter int DEN_W  = 19,
    parameter int PER_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [LOAD_W-1:0] load_i,
    output logic [PER_W-1:0]  period_o,
    output logic [PER_W-1:0]  offset_o,
    output logic              busy_o,
    output logic              upd_o
);
    localparam logic [NUM_W-1:0] NUM_CONST = NUM_W'(SCALE * (2 ** FRAC_W));
    localparam logic [DEN_W-1:0] DEN_BIAS  = DEN_W'(DEN_C * (2 ** FRAC_W));

    logic [DEN_W-1:0] den;
    logic [PER_W-1:0] quo;
    logic             div_done;
    logic [PER_W-1:0] per_new;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] offset_q;

    // Denominator from the load value present on the wrap edge.
    always_comb begin
        den = DEN_W'(DEN_K) * DEN_W'(load_i) + DEN_BIAS;
    end

    hb_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W),
        .OUT_W (PER_W)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wrap_i),
        .num_i   (NUM_CONST),
        .den_i   (den),
        .busy_o  (busy_o),
        .done_o  (div_done),
        .quo_o   (quo)
    );

    // New period from the quotient plus the floor.
    always_comb begin
        per_new = quo + PER_W'(BASE);
    end

    // Period and second-flash offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            offset_q <= '0;
        end else if (div_done) begin
            period_q <= per_new;
            offset_q <= per_new >> 2;
        end
    end

    assign period_o = period_q;
    assign offset_o = offset_q;
    assign upd_o    = div_done;

endmodule

// File: rtl/hb_beat_counter.sv
// Tick-driven beat counter and LED register. The counter steps 0..period
// and wraps. The LED is set when the counter lands on 0 or on the offset
// and cleared when it lands on ON_TICKS or offset+ON_TICKS. Set wins.
// Assumes: period_i and offset_i are stable on any tick.
module hb_beat_counter
    import hb_pkg::*;
#(
    parameter int PER_W    = 7,
    parameter int ON_TICKS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PER_W-1:0] offset_i,
    output logic             wrap_o,
    output logic [PER_W-1:0] cnt_o,
    output logic             led_o
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] cnt_nxt;
    logic [PER_W:0]   off_end;
    logic             led_q;
    led_act_e         act;

    // Wrap decision and next count value.
    always_comb begin
        wrap_o  = tick_i && (cnt_q >= period_i);
        cnt_nxt = wrap_o ? '0 : cnt_q + PER_W'(1);
        off_end = {1'b0, offset_i} + (PER_W+1)'(ON_TICKS);
    end

    // LED action for the count the tick is about to produce.
    always_comb begin
        if (cnt_nxt == '0 || cnt_nxt == offset_i) begin
            act = LED_SET;
        end else if (cnt_nxt == PER_W'(ON_TICKS) || {1'b0, cnt_nxt} == off_end) begin
            act = LED_CLR;
        end else begin
            act = LED_HOLD;
        end
    end

    // Counter and LED registers, advanced only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            led_q <= 1'b0;
        end else if (tick_i) begin
            cnt_q <= cnt_nxt;
            case (act)
                LED_SET: led_q <= 1'b1;
                LED_CLR: led_q <= 1'b0;
                default: led_q <= led_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;
    assign led_o = led_q;

endmodule

// File: rtl/heartbeat_led.sv
// Top of the load-dependent heartbeat LED. Joins the beat counter with
// the period engine. A wrap from the counter starts a new period calculation.
// Assumes: ticks are at least hb_pkg::min_tick_gap(NUM_W) clocks apart.
module heartbeat_led #(
    parameter int LOAD_W     = 16,
    parameter int FRAC_W     = 11,
    parameter int SCALE      = 672,
    parameter int DEN_K      = 5,
    parameter int DEN_C      = 7,
    parameter int BASE_TICKS = 30,
    parameter int ON_TICKS   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [LOAD_W-1:0] load_i,
    output logic              led_o
);
    localparam int NUM_VAL = SCALE * (2 ** FRAC_W);
    localparam int NUM_W   = $clog2(NUM_VAL + 1);
    localparam int DEN_W   = $clog2(DEN_K * (2 ** LOAD_W) + DEN_C * (2 ** FRAC_W) + 1);
    localparam int PER_W   = $clog2(SCALE / DEN_C + BASE_TICKS + 1);

    logic             wrap;
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] offset;
    logic             calc_busy;
    logic             period_upd;

    hb_beat_counter #(
        .PER_W    (PER_W),
        .ON_TICKS (ON_TICKS)
    ) beat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .period_i (period),
        .offset_i (offset),
        .wrap_o   (wrap),
        .cnt_o    (cnt),
        .led_o    (led_o)
    );

    hb_period_calc #(
        .LOAD_W (LOAD_W),
        .FRAC_W (FRAC_W),
        .SCALE  (SCALE),
        .DEN_K  (DEN_K),
        .DEN_C  (DEN_C),
        .BASE   (BASE_TICKS),
        .NUM_W  (NUM_W),
        .DEN_W  (DEN_W),
        .PER_W  (PER_W)
    ) calc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .load_i   (load_i),
        .period_o (period),
        .offset_o (offset),
        .busy_o   (calc_busy),
        .upd_o    (period_upd)
    );

endmodule

// File: rtl/hb_checker.sv
// Temporal checks on the heartbeat LED, attached by bind to the top.
// Assumes: the internal signal names of heartbeat_led listed in the bind.
module hb_checker #(
    parameter int PER_W = 7,
    parameter int BASE  = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [PER_W-1:0] cnt,
    input logic [PER_W-1:0] period,
    input logic [PER_W-1:0] offset,
    input logic             busy,
    input logic             upd,
    input logic             led
);
    // R1: without a tick, the counter and the LED hold.
    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(led)));

    // R2: the counter never passes the period.
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= period);

    // R2: a tick at or above the period returns the counter to zero.
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= period) |=> (cnt == '0));

    // R5: the wrap tick lights the LED.
    a_r5_lit_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= period) |=> led);

    // R3: a fresh period is never below the floor.
    a_r3_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (period >= PER_W'(BASE)));

    // R4: the offset is a quarter of the fresh period.
    a_r4_quarter_offset: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (((PER_W+2)'(offset) * 4 <= (PER_W+2)'(period)) &&
                 ((PER_W+2)'(period) < (PER_W+2)'(offset) * 4 + 4)));

    // R9: no tick arrives while a period calculation is pending.
    a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !busy);

endmodule

bind heartbeat_led hb_checker #(
    .PER_W (PER_W),
    .BASE  (BASE_TICKS)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .cnt    (cnt),
    .period (period),
    .offset (offset),
    .busy   (calc_busy),
    .upd    (period_upd),
    .led    (led_o)
);

// File: tb/heartbeat_led_tb_top.sv
`timescale 1ns/1ps
module heartbeat_led_tb_top;
    localparam int GAP = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] load = '0;
    logic        led;

    int vec = 0;
    int bad = 0;
    int mcnt = 0;
    int mper = 0;
    int moff = 0;
    int wraps = 0;
    bit mled = 1'b0;
    string phase = "";

    always #2.5 clk = ~clk;

    heartbeat_led dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .load_i (load),
        .led_o  (led)
    );

    // R3 period law computed from the stated formula.
    function automatic int exp_period(input int l);
        return 1376256 / (5 * l + 14336) + 30;
    endfunction

    task automatic chk(input string tag, input logic got, input bit exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: led=%0b expected %0b (count %0d period %0d load %0d)",
                     tag, got, exp, mcnt, mper, load);
        end
    endtask

    // One tick, model update, LED compare, then idle clocks checked for hold.
    task automatic one_tick();
        string tag;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (mcnt >= mper) begin
            mcnt = 0;
            mper = exp_period(int'(load));
            moff = mper / 4;
            wraps++;
        end else begin
            mcnt++;
        end
        if (mcnt == 0) begin
            mled = 1'b1;
            tag = (wraps == 1) ? "R8" : "R3 R5";
        end else if (mcnt == moff) begin
            mled = 1'b1;
            tag = "R4 R5";
        end else if (mcnt == 7 || mcnt == moff + 7) begin
            mled = 1'b0;
            tag = "R6";
        end else if (mcnt == 1) begin
            tag = "R9";
        end else begin
            tag = "R2";
        end
        if (phase != "") tag = phase;
        chk(tag, led, mled);
        for (int i = 0; i < GAP - 2; i++) begin
            @(negedge clk);
            chk("R1", led, mled);
        end
    endtask

    task automatic run_beats(input int l, input int n);
        int target;
        load = 16'(l);
        target = wraps + n;
        while (wraps < target) one_tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R8", led, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", led, 1'b0);

        // Stated curve points and the top code, R3.
        run_beats(0, 3);
        run_beats(2048, 1);
        run_beats(10240, 1);
        run_beats(65535, 2);
        run_beats(1024, 1);

        // Coarse sweep of the load range.
        for (int l = 0; l < 65536; l += 8191) run_beats(l, 1);

        // R7: load jumps in the middle of a beat that was sized for load 0.
        run_beats(0, 1);
        for (int i = 0; i < 20; i++) one_tick();
        load = 16'd50000;
        phase = "R7";
        run_beats(50000, 1);
        phase = "";
        run_beats(50000, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule